// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master that walks a multi-channel successive-approximation converter through a scan. A one-cycle `start` latches a channel-enable mask. For each enabled channel, lowest index first, the block sends one 16-bit command frame. The command selects manual channel addressing, allows the settings to be written, names the channel and picks the input range. The converter answers each command two frames later. The sequencer therefore appends two frames that carry an all-zero word, and it pairs every reply with the command that caused it. The first two replies of a scan are discarded.

Each paired reply leaves the block as a channel/sample pair on `res_valid`, `res_chan` and `res_data`. The sample is taken from the left-justified data field of the reply. A `done` pulse closes the scan and `busy` covers the whole scan. If the address field of a reply does not match the channel that is due, a sticky `chan_err` flag is set. The next accepted start clears it.

The serial clock comes from the system clock through a parameterised divider and uses mode 0: it idles low, and data is captured on the rising edge. Chip select goes low only around a single frame. It stays high for at least one serial-clock period between frames, and it stays high once the scan has ended.

Top module: `adc_scan_seq`

## Requirements
- R1: Each frame holds `cs_n` low for exactly 16 serial-clock rising edges and sends MSB first. `sclk` is low whenever `cs_n` is high. MOSI changes only while `sclk` is low.
- R2: A command word has bit 12 = 1 (manual channel mode), bit 11 = 1 (settings write), the channel in bits 10:7, bit 6 = `WIDE_RANGE`, and zeros in every other bit. The two trailing frames of a scan send 16'h0000.
- R3: Commands go out for the set bits of the latched mask in ascending channel order.
- R4: A scan has exactly popcount(mask)+2 frames. This includes an empty mask, which gives 2 frames. Between frames `cs_n` is high for at least 2*CLK_DIV system cycles.
- R5: The reply in frame k+2 belongs to the k-th command. `res_chan` is that command's channel. `res_data` is reply bits 11 down to 12-RES_BITS.
- R6: Replies in the first two frames of a scan produce no result. A scan delivers exactly popcount(mask) results.
- R7: `chan_err` is set when the reply bits 15:12 differ from the expected channel. It stays set until the next accepted start, which clears it.
- R8: `busy` rises in the cycle after an accepted start and stays high until `done`. A `start` while `busy` is high has no effect on frames, commands or results.
- R9: `done` is a one-cycle pulse, coincident with the last result when the mask is not empty. In the same cycle `busy` falls. After it, `cs_n` stays high and no further frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| ch_mask | input | N_CH | Channel enable mask, latched on start |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command data |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Channel of the result |
| res_data | output | RES_BITS | Sample value |
| done | output | 1 | End-of-scan pulse |
| chan_err | output | 1 | Sticky reply-address mismatch flag |

## Verification
`busy` is due one cycle after the edge that samples `start`, and chip select first falls two cycles after that edge. Each frame lasts 32*CLK_DIV system cycles with chip select low, then a gap of 2*CLK_DIV cycles. A result is due on the cycle after the gap of frames three onward, and `done` with `busy` low is due on that same cycle for the last frame. The bench drives inputs and samples outputs on the falling system-clock edge, so every registered result is read half a cycle after the edge that set it. The converter model answers on serial-clock edges and records every command, so frame counts, command words and reply pairing are checked against its own log.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 4;
  localparam int MODE_BIT  = 12;
  localparam int WREN_BIT  = 11;
  localparam int CH_LSB    = 7;
  localparam int RANGE_BIT = 6;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] ch;
  } pend_t;

  function automatic logic [FRAME_W-1:0] make_cmd(input logic [ADDR_W-1:0] ch,
                                                  input logic wide);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[MODE_BIT] = 1'b1;
    w[WREN_BIT] = 1'b1;
    w[CH_LSB +: ADDR_W] = ch;
    w[RANGE_BIT] = wide;
    return w;
  endfunction
endpackage

// File: rtl/adc_seq_chan_pick.sv
module adc_seq_chan_pick
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic [N_CH-1:0]   mask,
  output logic              any,
  output logic [ADDR_W-1:0] idx
);
  // lowest set bit wins: scan downward so the last write is the lowest index
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (mask[i]) idx = i[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_frame_engine.sv
module adc_seq_frame_engine
  import adc_seq_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               fdone,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int GAP  = 2 * CLK_DIV;
  localparam int CW   = $clog2(GAP + 1);
  localparam int BW   = $clog2(FRAME_W);
  localparam logic [CW-1:0] HALF_END = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  typedef enum logic [1:0] {F_IDLE, F_LOW, F_HIGH, F_GAP} fstate_t;

  fstate_t            st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx_word <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      fdone   <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (st)
        F_IDLE: begin
          if (go) begin
            sh   <= tx_word;
            mosi <= tx_word[FRAME_W-1];
            cs_n <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            st   <= F_LOW;
          end
        end
        F_LOW: begin
          if (cnt == HALF_END) begin
            cnt     <= '0;
            sclk    <= 1'b1;
            rx_word <= {rx_word[FRAME_W-2:0], miso};
            st      <= F_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        F_HIGH: begin
          if (cnt == HALF_END) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bitn == LAST_BIT) begin
              cs_n <= 1'b1;
              mosi <= 1'b0;
              st   <= F_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[FRAME_W-2:0], 1'b0};
              mosi <= sh[FRAME_W-2];
              st   <= F_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        F_GAP: begin
          if (cnt == GAP_END) begin
            cnt   <= '0;
            fdone <= 1'b1;
            st    <= F_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int   N_CH       = 16,
  parameter int   RES_BITS   = 12,
  parameter int   CLK_DIV    = 2,
  parameter logic WIDE_RANGE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N_CH-1:0]     ch_mask,
  input  logic                miso,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                busy,
  output logic                res_valid,
  output logic [ADDR_W-1:0]   res_chan,
  output logic [RES_BITS-1:0] res_data,
  output logic                done,
  output logic                chan_err
);
  localparam int FW = $clog2(N_CH + 3);
  localparam int DATA_MSB = FRAME_W - ADDR_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} sstate_t;

  sstate_t            st;
  logic [N_CH-1:0]    rem;
  logic [FW-1:0]      frames_left;
  pend_t              pipe [3];
  logic               go;
  logic [FRAME_W-1:0] tx_word;
  logic               fdone;
  logic [FRAME_W-1:0] rx_word;
  logic               pick_any;
  logic [ADDR_W-1:0]  pick_idx;
  logic [FW-1:0]      mask_pop;

  always_comb begin
    mask_pop = FW'(2);
    for (int i = 0; i < N_CH; i++) mask_pop = mask_pop + FW'(ch_mask[i]);
  end

  adc_seq_chan_pick #(.N_CH(N_CH)) u_pick (
    .mask (rem),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  adc_seq_frame_engine #(.CLK_DIV(CLK_DIV)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .tx_word (tx_word),
    .miso    (miso),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .fdone   (fdone),
    .rx_word (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      rem         <= '0;
      frames_left <= '0;
      go          <= 1'b0;
      tx_word     <= '0;
      busy        <= 1'b0;
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_data    <= '0;
      done        <= 1'b0;
      chan_err    <= 1'b0;
      for (int i = 0; i < 3; i++) pipe[i] <= '0;
    end else begin
      go        <= 1'b0;
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            rem         <= ch_mask;
            frames_left <= mask_pop;
            chan_err    <= 1'b0;
            busy        <= 1'b1;
            for (int i = 0; i < 3; i++) pipe[i] <= '0;
            st          <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          go      <= 1'b1;
          pipe[2] <= pipe[1];
          pipe[1] <= pipe[0];
          if (pick_any) begin
            tx_word       <= make_cmd(pick_idx, WIDE_RANGE);
            rem[pick_idx] <= 1'b0;
            pipe[0]       <= '{vld: 1'b1, ch: pick_idx};
          end else begin
            tx_word <= '0;
            pipe[0] <= '0;
          end
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (fdone) begin
            if (pipe[2].vld) begin
              res_valid <= 1'b1;
              res_chan  <= pipe[2].ch;
              res_data  <= rx_word[DATA_MSB -: RES_BITS];
              if (rx_word[FRAME_W-1 -: ADDR_W] != pipe[2].ch) chan_err <= 1'b1;
            end
            if (frames_left == FW'(1)) begin
              done <= 1'b1;
              busy <= 1'b0;
              st   <= S_IDLE;
            end else begin
              frames_left <= frames_left - 1'b1;
              st          <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic done,
  input logic res_valid,
  input logic chan_err
);
  localparam int GAP = 2 * CLK_DIV;
  localparam int HW  = $clog2(GAP + 2);

  logic [HW-1:0] hi_cnt;
  logic [5:0]    edge_cnt;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= HW'(GAP);
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP)) hi_cnt <= hi_cnt + 1'b1;
      if (cs_n) edge_cnt <= '0;
      else if (sclk && !sclk_q) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  a_r1_sixteen_edges: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> edge_cnt == 6'd16);
  a_r4_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt >= HW'(GAP));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (chan_err && !(start && !busy)) |=> chan_err);
  a_r8_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r8_idle_cs_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r6_result_in_scan: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (.*);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int N_CH = 16;
  localparam int RES  = 12;
  localparam int DIV  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N_CH-1:0] ch_mask = '0;
  logic miso;
  logic sclk, cs_n, mosi, busy, res_valid, done, chan_err;
  logic [3:0] res_chan;
  logic [RES-1:0] res_data;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  adc_scan_seq #(.N_CH(N_CH), .RES_BITS(RES), .CLK_DIV(DIV), .WIDE_RANGE(1'b1)) u_adc_scan_seq (
    .clk(clk), .rst(rst), .start(start), .ch_mask(ch_mask), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .done(done), .chan_err(chan_err)
  );

  // converter model
  int          fr = 0;
  int          bad_frame = -1;
  logic [15:0] cmd_log [64];
  logic [3:0]  hist_ch [64];
  logic [15:0] s_word = '0;
  logic [15:0] s_rx = '0;
  int          s_nf = 0;

  function automatic logic [11:0] sample_of(input logic [3:0] ch);
    return 12'((int'(ch) * 12'h123 + 12'h05A) & 12'hFFF);
  endfunction

  assign miso = (s_nf < 16) ? s_word[15 - s_nf] : 1'b0;

  always @(negedge cs_n) begin
    if (fr >= 2 && fr < 64) begin
      logic [3:0] c;
      c = hist_ch[fr-2];
      s_word = {(fr == bad_frame) ? (c ^ 4'h1) : c, sample_of(c)};
    end else begin
      s_word = 16'hF0F0;
    end
  end
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) s_nf = 0;
    else s_nf = s_nf + 1;
  end
  always @(posedge sclk) if (!cs_n) s_rx = {s_rx[14:0], mosi};
  always @(posedge cs_n) begin
    if (!rst && fr < 64) begin
      cmd_log[fr] = s_rx;
      hist_ch[fr] = s_rx[10:7];
      fr = fr + 1;
    end
  end

  // result monitor
  int         res_cnt = 0;
  int         done_cnt = 0;
  logic [3:0] rc_log [32];
  logic [11:0] rd_log [32];
  logic       done_busy, done_cs, done_res;

  always @(negedge clk) begin
    if (res_valid && res_cnt < 32) begin
      rc_log[res_cnt] = res_chan;
      rd_log[res_cnt] = res_data;
      res_cnt = res_cnt + 1;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      done_busy = busy;
      done_cs = cs_n;
      done_res = res_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
    chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    chk(done == 1'b0 && res_valid == 1'b0, "R9 reset strobes", int'({done, res_valid}), 0);
    chk(chan_err == 1'b0, "R7 reset err", int'(chan_err), 0);
  endtask

  task automatic run_scan(input logic [15:0] m, input int bad, input bit poke, input string tag);
    int n;
    int k;
    int wd;
    int fr_end;
    logic [3:0] exp_ch [16];
    n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin exp_ch[n] = 4'(i); n++; end
    fr = 0; res_cnt = 0; done_cnt = 0; bad_frame = bad;
    @(negedge clk);
    ch_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R8 busy after start ", tag}, int'(busy), 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      ch_mask = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy held", int'(busy), 1);
    end
    wd = 0;
    while (done_cnt == 0 && wd < 6000) begin @(negedge clk); wd++; end
    chk(done_cnt == 1, {"R9 done seen ", tag}, done_cnt, 1);
    chk(fr == n + 2, {"R4 frame count ", tag}, fr, n + 2);
    for (int i = 0; i < n; i++) begin
      k = int'({3'b001, 1'b1, exp_ch[i], 1'b1, 6'b0});
      chk(cmd_log[i] == 16'(k), {"R2 R3 command ", tag}, int'(cmd_log[i]), k);
    end
    chk(cmd_log[n] == 16'h0 && cmd_log[n+1] == 16'h0, {"R2 trailing zero ", tag},
        int'({cmd_log[n], cmd_log[n+1]}), 0);
    chk(res_cnt == n, {"R6 result count ", tag}, res_cnt, n);
    for (int i = 0; i < n && i < res_cnt; i++) begin
      chk(rc_log[i] == exp_ch[i], {"R5 result chan ", tag}, int'(rc_log[i]), int'(exp_ch[i]));
      chk(rd_log[i] == sample_of(exp_ch[i]), {"R5 result data ", tag},
          int'(rd_log[i]), int'(sample_of(exp_ch[i])));
    end
    chk(chan_err == (bad >= 2 && bad < n + 2), {"R7 error flag ", tag},
        int'(chan_err), int'(bad >= 2 && bad < n + 2));
    chk(done_busy == 1'b0 && done_cs == 1'b1, {"R9 done state ", tag},
        int'({done_busy, done_cs}), 1);
    chk(done_res == (n > 0), {"R9 done with last result ", tag}, int'(done_res), int'(n > 0));
    fr_end = fr;
    repeat (200) @(negedge clk);
    chk(fr == fr_end && cs_n == 1'b1 && done_cnt == 1, {"R9 quiet after done ", tag}, fr, fr_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    run_scan(16'h0001, -1, 1'b0, "single");
    run_scan(16'hA5C3, -1, 1'b0, "sparse");
    run_scan(16'h8000, -1, 1'b0, "top");
    run_scan(16'h0000, -1, 1'b0, "empty");
    run_scan(16'h0006, 3, 1'b0, "mismatch");
    run_scan(16'h0030, -1, 1'b1, "start while busy");
    run_scan(16'hFFFF, -1, 1'b0, "all");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule